// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block receives configuration words over a three-wire serial link (frame enable, serial clock, serial data) and keeps them in seven control registers of unequal width, 41 bits in all. Their contents drive the parallel control ports of a clock-recovery front end. All three serial inputs and the chip-select input are oversampled by the system clock through a synchronizer, so the serial link may be much slower than the system clock and unrelated to it. Each rising edge of the serial clock seen while the enable is high shifts in one bit. The frame is acted on when the enable drops.

Three of the registers together describe the clock divider: the low byte of a 12-bit divisor, its upper nibble, and a select register that holds the post-divider and pump-current codes. These three are staged. The divider ports change in one step, and only after each of the three has been written since the last update, so that a partly written divisor never reaches the divider. Any frame also starts a readback. The whole register contents are loaded into a scan chain, which shifts one bit per serial clock edge onto a serial output. The chip-select input and a sleep bit together set one of three power levels.

Top module: `ser_cfg_bank`

## Requirements
- R1: While reset is asserted, every register output, `ser_out` and `pwr_state` read zero.
- R2: A write frame is exactly 11 serial clock rising edges while `ser_en` is high: 8 data bits and then 3 address bits, each field MSB first. The write takes effect when `ser_en` falls.
- R3: Address map and widths: 0 = divisor low (8), 1 = divisor high (4), 2 = divider select (4; bits 1:0 post-divider, bits 3:2 pump current), 3 = sync delay (5), 4 = clock delay (5), 5 = output control (8), 6 = mode (7; bit 0 = sleep). A narrower register keeps the low bits of the data byte, and the rest of the byte is dropped.
- R4: `div_ratio` = {high, low}, `post_sel` and `pump_sel` change only when addresses 0, 1 and 2 have each been written since the last update. They then take the written values together, and the record of written addresses is cleared.
- R5: On the rising edge of `ser_en`, a snapshot of the register contents is taken. `ser_out` presents it from address 0 up to address 6, MSB first within each register, and advances one bit per serial clock rising edge. For addresses 0 to 2 the snapshot holds the written values, even when they are not yet applied.
- R6: A frame with any bit count other than 11, a readback frame included, changes no register.
- R7: A well-formed frame to address 7 changes no register.
- R8: `pwr_state` is 2 (full) when chip select is high and sleep is 0, 1 (registers kept) when chip select is high and sleep is 1, and 0 (off) when chip select is low. Register contents persist in every level.
- R9: While `pwr_state` is 0, frames are ignored and `ser_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Frame enable, active high |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_din | input | 1 | Serial data in |
| chip_sel | input | 1 | Chip select, low selects the off level |
| ser_out | output | 1 | Readback serial data |
| div_ratio | output | 12 | Applied divisor |
| post_sel | output | 2 | Applied post-divider code |
| pump_sel | output | 2 | Applied pump-current code |
| dly_sync | output | 5 | Sync delay setting |
| dly_clk | output | 5 | Clock delay setting |
| out_ctrl | output | 8 | Output control bits |
| misc_ctrl | output | 7 | Mode bits, bit 0 is sleep |
| pwr_state | output | 2 | Power level: 0 off, 1 kept, 2 full |

## Verification
A miscounted bit or a shifted field shows up on the parallel ports within a few system clocks of the enable falling. The bench compares every register output with a behavioural model on every clock outside that short settling window. A stale set of divider flags appears only later, as a divisor that moves after fewer than three writes or that fails to move after all three, so the sequence deliberately rewrites a single divider register after an update. Staged values that have not yet been applied are visible only in the serial readback, which is compared bit by bit against the model.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;

  localparam int NUM_REGS   = 7;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int FRAME_BITS = DATA_W + ADDR_W;
  localparam int NUM_DIV    = 3;
  localparam int POST_W     = 2;

  // widths of the registers, address 0 first
  localparam int REG_W [NUM_REGS] = '{8, 4, 4, 5, 5, 8, 7};

  typedef enum logic [1:0] {
    PWR_OFF  = 2'b00,
    PWR_KEEP = 2'b01,
    PWR_FULL = 2'b10
  } pwr_e;

  function automatic int sum_widths(int upto);
    int acc;
    acc = 0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (k <= upto) acc += REG_W[k];
    end
    return acc;
  endfunction

  localparam int BANK_W = sum_widths(NUM_REGS - 1);
  localparam int LIVE_W = sum_widths(NUM_DIV - 1);
  localparam int DIV_W  = REG_W[0] + REG_W[1];
  localparam int PUMP_W = REG_W[2] - POST_W;

  // address 0 occupies the top of the flat bank, so the bank is the scan order
  function automatic int reg_lsb(int idx);
    return BANK_W - sum_widths(idx);
  endfunction

  function automatic int live_lsb(int idx);
    return reg_lsb(idx) - (BANK_W - LIVE_W);
  endfunction

  function automatic logic [DATA_W-1:0] frame_data(logic [FRAME_BITS-1:0] f);
    return f[FRAME_BITS-1 -: DATA_W];
  endfunction

  function automatic logic [ADDR_W-1:0] frame_addr(logic [FRAME_BITS-1:0] f);
    return f[ADDR_W-1:0];
  endfunction

  function automatic pwr_e pwr_level(logic cs, logic sleep);
    if (!cs) return PWR_OFF;
    if (sleep) return PWR_KEEP;
    return PWR_FULL;
  endfunction

endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/ser_cfg_frame_rx.sv
module ser_cfg_frame_rx
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              accept,
  output logic              frame_start,
  output logic              bit_tick,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  localparam int CNT_W = $clog2(FRAME_BITS + 2);

  logic                  en_q;
  logic                  sclk_q;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      nbits;
  logic                  frame_end;

  assign frame_start = en_s & ~en_q;
  assign frame_end   = ~en_s & en_q;
  assign bit_tick    = en_s & en_q & sclk_s & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
      shreg  <= '0;
      nbits  <= '0;
    end else begin
      en_q   <= en_s;
      sclk_q <= sclk_s;
      if (bit_tick) shreg <= {shreg[FRAME_BITS-2:0], din_s};
      if (frame_start) nbits <= '0;
      else if (bit_tick && (nbits != {CNT_W{1'b1}})) nbits <= nbits + 1'b1;
    end
  end

  assign wr_pulse = frame_end && (nbits == CNT_W'(FRAME_BITS)) && accept;
  assign wr_data  = frame_data(shreg);
  assign wr_addr  = frame_addr(shreg);

endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
  import ser_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_pulse,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [BANK_W-1:0]  bank,
  output logic [LIVE_W-1:0]  live,
  output logic [NUM_DIV-1:0] div_flags,
  output logic               commit_pulse
);

  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int W = REG_W[i];
    localparam int L = reg_lsb(i);
    logic [W-1:0] q;

    assign hit[i] = wr_pulse && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (hit[i]) q <= wr_data[W-1:0];
    end

    assign bank[L +: W] = q;
  end

  assign commit_pulse = &div_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_flags <= '0;
      live      <= '0;
    end else begin
      div_flags <= (commit_pulse ? '0 : div_flags) | hit[NUM_DIV-1:0];
      if (commit_pulse) live <= bank[BANK_W-1 -: LIVE_W];
    end
  end

endmodule

// File: rtl/ser_cfg_scan.sv
module ser_cfg_scan
  import ser_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic              blank,
  input  logic [BANK_W-1:0] par_in,
  output logic              ser_out
);

  logic [BANK_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else if (load) chain <= par_in;
    else if (shift) chain <= {chain[BANK_W-2:0], 1'b0};
  end

  assign ser_out = chain[BANK_W-1] & ~blank;

endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
  import ser_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_en,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                chip_sel,
  output logic                ser_out,
  output logic [DIV_W-1:0]    div_ratio,
  output logic [POST_W-1:0]   post_sel,
  output logic [PUMP_W-1:0]   pump_sel,
  output logic [REG_W[3]-1:0] dly_sync,
  output logic [REG_W[4]-1:0] dly_clk,
  output logic [REG_W[5]-1:0] out_ctrl,
  output logic [REG_W[6]-1:0] misc_ctrl,
  output logic [1:0]          pwr_state
);

  logic               en_s, sclk_s, din_s, cs_s;
  logic               frame_start, bit_tick, wr_pulse, commit_pulse;
  logic [ADDR_W-1:0]  wr_addr;
  logic [DATA_W-1:0]  wr_data;
  logic [BANK_W-1:0]  bank;
  logic [LIVE_W-1:0]  live;
  logic [NUM_DIV-1:0] div_flags;
  pwr_e               pwr_q;

  ser_cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_en, ser_clk, ser_din, chip_sel}),
    .q     ({en_s, sclk_s, din_s, cs_s})
  );

  ser_cfg_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_s        (en_s),
    .sclk_s      (sclk_s),
    .din_s       (din_s),
    .accept      (pwr_q != PWR_OFF),
    .frame_start (frame_start),
    .bit_tick    (bit_tick),
    .wr_pulse    (wr_pulse),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data)
  );

  ser_cfg_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_pulse     (wr_pulse),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .bank         (bank),
    .live         (live),
    .div_flags    (div_flags),
    .commit_pulse (commit_pulse)
  );

  ser_cfg_scan u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (frame_start),
    .shift   (bit_tick),
    .blank   (pwr_q == PWR_OFF),
    .par_in  (bank),
    .ser_out (ser_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= PWR_OFF;
    else pwr_q <= pwr_level(cs_s, misc_ctrl[0]);
  end

  assign pwr_state = pwr_q;
  assign div_ratio = {live[live_lsb(1) +: REG_W[1]], live[live_lsb(0) +: REG_W[0]]};
  assign post_sel  = live[live_lsb(2) +: POST_W];
  assign pump_sel  = live[live_lsb(2) + POST_W +: PUMP_W];
  assign dly_sync  = bank[reg_lsb(3) +: REG_W[3]];
  assign dly_clk   = bank[reg_lsb(4) +: REG_W[4]];
  assign out_ctrl  = bank[reg_lsb(5) +: REG_W[5]];
  assign misc_ctrl = bank[reg_lsb(6) +: REG_W[6]];

endmodule

// File: rtl/ser_cfg_bank_chk.sv
module ser_cfg_bank_chk
  import ser_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_pulse,
  input logic               commit_pulse,
  input logic [NUM_DIV-1:0] div_flags,
  input logic [DIV_W-1:0]   div_ratio,
  input logic [POST_W-1:0]  post_sel,
  input logic [PUMP_W-1:0]  pump_sel,
  input logic [REG_W[3]-1:0] dly_sync,
  input logic [REG_W[4]-1:0] dly_clk,
  input logic [REG_W[5]-1:0] out_ctrl,
  input logic [REG_W[6]-1:0] misc_ctrl,
  input logic [1:0]         pwr_state
);

  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable({div_ratio, post_sel, pump_sel}));

  // R4
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> (div_flags == '0));

  // R4
  write_commit_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_pulse, commit_pulse}));

  // R2
  direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable({dly_sync, dly_clk, out_ctrl, misc_ctrl}));

  // R9
  off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00) |-> !wr_pulse);

  // R8
  pwr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);

endmodule

bind ser_cfg_bank ser_cfg_bank_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_pulse     (wr_pulse),
  .commit_pulse (commit_pulse),
  .div_flags    (div_flags),
  .div_ratio    (div_ratio),
  .post_sel     (post_sel),
  .pump_sel     (pump_sel),
  .dly_sync     (dly_sync),
  .dly_clk      (dly_clk),
  .out_ctrl     (out_ctrl),
  .misc_ctrl    (misc_ctrl),
  .pwr_state    (pwr_state)
);

// File: tb/ser_cfg_bank_tb_top.sv
module ser_cfg_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SETTLE     = 10;
  localparam int NREG       = 7;
  localparam int WID [NREG] = '{8, 4, 4, 5, 5, 8, 7};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, chip_sel = 1'b1;
  logic        ser_out;
  logic [11:0] div_ratio;
  logic [1:0]  post_sel, pump_sel, pwr_state;
  logic [4:0]  dly_sync, dly_clk;
  logic [7:0]  out_ctrl;
  logic [6:0]  misc_ctrl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ser_cfg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_din(ser_din), .chip_sel(chip_sel), .ser_out(ser_out),
    .div_ratio(div_ratio), .post_sel(post_sel), .pump_sel(pump_sel),
    .dly_sync(dly_sync), .dly_clk(dly_clk), .out_ctrl(out_ctrl),
    .misc_ctrl(misc_ctrl), .pwr_state(pwr_state)
  );

  int n_checks = 0, n_fail = 0, mon_err = 0;
  bit mon_on = 0, settle = 0, finished = 0;

  // behavioural model
  int mreg [NREG];
  int mlo = 0, mhi = 0, msel = 0;
  bit [2:0] mflag = '0;
  bit mcs = 1;

  function automatic int model_pwr();
    if (!mcs) return 0;
    if ((mreg[6] & 1) != 0) return 1;
    return 2;
  endfunction

  function automatic logic [40:0] model_outs();
    return {4'(mhi), 8'(mlo), 2'(msel), 2'(msel >> 2), 5'(mreg[3]),
            5'(mreg[4]), 8'(mreg[5]), 7'(mreg[6])};
  endfunction

  task automatic model_apply(int d, int a);
    if (a < NREG) begin
      mreg[a] = d % (1 << WID[a]);
      if (a < 3) mflag[a] = 1'b1;
      if (mflag == 3'b111) begin
        mlo = mreg[0]; mhi = mreg[1]; msel = mreg[2]; mflag = '0;
      end
    end
  endtask

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // per-clock comparison of the register outputs against the model (R2 R3 R4)
  always @(negedge clk) begin
    if (mon_on && !settle) begin
      if ({div_ratio, post_sel, pump_sel, dly_sync, dly_clk, out_ctrl, misc_ctrl} !== model_outs()) begin
        mon_err++;
        if (mon_err < 5)
          $display("FAIL R4 clock compare: actual %0h expected %0h",
                   {div_ratio, post_sel, pump_sel, dly_sync, dly_clk, out_ctrl, misc_ctrl}, model_outs());
      end
    end
  end

  task automatic frame(input logic [7:0] d, input logic [2:0] a, input int nbits);
    logic [10:0] word;
    word = {d, a};
    @(negedge clk); ser_en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 11) ? word[10 - i] : 1'b0;
      repeat (HALF) @(negedge clk); ser_clk = 1'b1;
      repeat (HALF) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    settle = 1; ser_en = 1'b0;
    if (nbits == 11 && model_pwr() != 0) model_apply(int'(d), int'(a));
    repeat (SETTLE) @(negedge clk);
    settle = 0;
  endtask

  task automatic readback(string req);
    int bad;
    logic e;
    bad = 0;
    @(negedge clk); ser_en = 1'b1;
    repeat (HALF) @(negedge clk);
    for (int r = 0; r < NREG; r++) begin
      for (int b = WID[r] - 1; b >= 0; b--) begin
        e = (model_pwr() == 0) ? 1'b0 : 1'(mreg[r] >> b);
        if (ser_out !== e) bad++;
        ser_clk = 1'b1; repeat (HALF) @(negedge clk);
        ser_clk = 1'b0; repeat (HALF) @(negedge clk);
      end
    end
    settle = 1; ser_en = 1'b0;
    repeat (SETTLE) @(negedge clk);
    settle = 0;
    check(req, "readback bit mismatches", 64'(bad), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [40:0] snap;
    for (int i = 0; i < NREG; i++) mreg[i] = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1", "register outputs in reset",
          64'({div_ratio, post_sel, pump_sel, dly_sync, dly_clk, out_ctrl, misc_ctrl}), 64'd0);
    check("R1", "ser_out in reset", 64'(ser_out), 64'd0);
    check("R1", "pwr_state in reset", 64'(pwr_state), 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    mon_on = 1;
    check("R8", "pwr_state full", 64'(pwr_state), 64'd2);

    // R3 LSB alignment, R2 MSB-first order
    frame(8'hFF, 3'd3, 11);
    check("R3", "dly_sync keeps low bits", 64'(dly_sync), 64'h1F);
    frame(8'hA5, 3'd5, 11);
    check("R2", "out_ctrl bit order", 64'(out_ctrl), 64'hA5);
    frame(8'h3C, 3'd4, 11);
    check("R3", "dly_clk keeps low bits", 64'(dly_clk), 64'h1C);

    // R4 staged divider
    frame(8'h34, 3'd0, 11);
    check("R4", "div after low only", 64'(div_ratio), 64'h000);
    frame(8'h0B, 3'd1, 11);
    check("R4", "div after low and high", 64'(div_ratio), 64'h000);
    readback("R5");
    frame(8'h06, 3'd2, 11);
    check("R4", "div after all three", 64'(div_ratio), 64'hB34);
    check("R4", "post_sel applied", 64'(post_sel), 64'd2);
    check("R4", "pump_sel applied", 64'(pump_sel), 64'd1);
    frame(8'h55, 3'd0, 11);
    check("R4", "div after lone rewrite", 64'(div_ratio), 64'hB34);

    // R6 wrong bit counts, R7 address 7
    frame(8'h77, 3'd4, 10);
    check("R6", "dly_clk after short frame", 64'(dly_clk), 64'h1C);
    frame(8'h77, 3'd4, 12);
    check("R6", "dly_clk after long frame", 64'(dly_clk), 64'h1C);
    snap = {div_ratio, post_sel, pump_sel, dly_sync, dly_clk, out_ctrl, misc_ctrl};
    frame(8'hFF, 3'd7, 11);
    check("R7", "outputs after address 7",
          64'({div_ratio, post_sel, pump_sel, dly_sync, dly_clk, out_ctrl, misc_ctrl}), 64'(snap));
    readback("R5");

    // R8 power levels
    frame(8'h01, 3'd6, 11);
    check("R8", "pwr_state kept", 64'(pwr_state), 64'd1);
    check("R8", "out_ctrl held in kept level", 64'(out_ctrl), 64'hA5);
    @(negedge clk); chip_sel = 1'b0; mcs = 0;
    repeat (6) @(negedge clk);
    check("R8", "pwr_state off", 64'(pwr_state), 64'd0);
    readback("R9");
    frame(8'h11, 3'd5, 11);
    check("R9", "out_ctrl after frame while off", 64'(out_ctrl), 64'hA5);
    @(negedge clk); chip_sel = 1'b1; mcs = 1;
    repeat (6) @(negedge clk);
    check("R8", "pwr_state back to kept", 64'(pwr_state), 64'd1);
    frame(8'h00, 3'd6, 11);
    check("R8", "pwr_state back to full", 64'(pwr_state), 64'd2);
    readback("R5");

    check("R4", "per-clock output mismatches", 64'(mon_err), 64'd0);
    finish_run();
  end

endmodule